// File: doc/BRIEF.md
# Two-Tone Sinusoidal Stimulus Synthesizer

This block produces the digital drive for a built-in linearity self-test of an analog path. Two direct digital synthesis channels each run a phase accumulator that steps by a programmable tuning word once per clock. The upper phase bits address a full-period table of signed sine samples. Adding the two tone samples gives one two-tone word, which goes to an external converter. From there it feeds the amplifier under test.

A third synthesis channel runs at the upper third-order intermodulation frequency, 2·f2 − f1. It gives the response analyzer a coherent reference for detecting that product. The tuning word for this channel is derived inside the block from the two tone words, so the reference follows every retuning of the tones. A single-tone input removes the second tone from the sum, which supports plain gain and frequency-response sweeps. Holding enable low parks every accumulator at phase zero, so each run starts from a known phase.

Top module: `tt_stim_gen`

## Requirements
- R1: While enable is high, each phase accumulator adds its tuning word once per clock, modulo 2^PHASE_W (default 24). The 8 most significant phase bits form the table address.
- R2: Table entry k (k = 0..255) holds round(127·sin(2πk/256)), rounded half away from zero, as an 8-bit two's-complement value.
- R3: `stim_o` is the 9-bit signed sum of the tone-1 and tone-2 samples. Two coincident full-scale samples give +254 or −254 with no wrap.
- R4: `ref_ftw_o` equals (2·`fr2_i` − `fr1_i`) mod 2^PHASE_W, combinationally, including when `fr1_i` exceeds 2·`fr2_i`.
- R5: `ref_o` carries the sample of the reference channel, whose accumulator steps by the R4 word. It is time-aligned with `stim_o`.
- R6: A clock edge with enable low sets all three phases to zero. Two edges later both outputs are 0, because entry 0 is 0.
- R7: When `single_i` is high at the output edge, `stim_o` equals the sign-extended tone-1 sample alone.
- R8: A phase value set at clock edge k is looked up at edge k+1 and appears on `stim_o` and `ref_o` after edge k+2.
- R9: While `rst_ni` is low, all phases and outputs are zero, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears all phases |
| single_i | input | 1 | Drop tone 2 from the summed stimulus |
| fr1_i | input | PHASE_W | Tuning word of tone 1 |
| fr2_i | input | PHASE_W | Tuning word of tone 2 |
| stim_o | output | SAMP_W+1 | Signed two-tone stimulus sample |
| ref_o | output | SAMP_W | Signed reference sample at 2·f2 − f1 |
| ref_ftw_o | output | PHASE_W | Derived tuning word of the reference channel |

## Verification
Two events can fall on the same clock edge: a switch into single-tone mode, and the cycle in which both tones reach full scale together. The bench sets both tuning words to a quarter of the phase range, so the peaks coincide every four cycles. It then toggles `single_i` on the cycles where the summed peak of ±254 would appear. A cycle-level reference model predicts whether each output word is the full sum or tone 1 alone. The bench compares `stim_o` and `ref_o` with that prediction on every clock. It also records that the extremes ±254 were reached without wrap while the mode was changing.

// File: rtl/tt_stim_pkg.sv
package tt_stim_pkg;

   // Fixed-point scale used while computing table contents
   localparam int FRAC_W = 30;
   // pi/2 scaled by 2^30
   localparam longint HALF_PI_Q = 64'sd1686629713;

   // Rounded sine entry k of a full-period table with 2^aw entries and peak amp.
   // Positive half-wave rounds half up; the negative half mirrors it, which gives
   // rounding half away from zero overall.
   function automatic int sine_entry(input int k, input int aw, input int amp);
      int     depth;
      int     quarter;
      int     q;
      int     m;
      bit     neg;
      longint x;
      longint x2;
      longint term;
      longint acc;
      longint v;
      depth   = 1 << aw;
      quarter = depth / 4;
      q       = k % (depth / 2);
      neg     = (k >= depth / 2);
      m       = (q > quarter) ? (depth / 2 - q) : q;
      x       = (longint'(m) * HALF_PI_Q) / longint'(quarter);
      x2      = (x * x) >>> FRAC_W;
      term    = x;
      acc     = x;
      for (int n = 1; n <= 9; n++) begin
         term = -(((term * x2) >>> FRAC_W) / longint'((2 * n) * (2 * n + 1)));
         acc  = acc + term;
      end
      v = (longint'(amp) * acc + (longint'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
      return neg ? -int'(v) : int'(v);
   endfunction

endpackage

// File: rtl/tt_phase_acc.sv
module tt_phase_acc #(
   parameter int PHASE_W = 24,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PHASE_W-1:0] ftw,
   output logic [ADDR_W-1:0]  addr
);

   if (PHASE_W < ADDR_W) begin : g_bad_width
      $error("tt_phase_acc: PHASE_W must be at least ADDR_W");
   end

   logic [PHASE_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase_q <= '0;
      else if (!en) phase_q <= '0;
      else          phase_q <= phase_q + ftw;
   end

   assign addr = phase_q[PHASE_W-1 -: ADDR_W];

   // R6: a disabled edge parks the phase at zero
   p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (phase_q == '0));

   // R1: an enabled edge advances by exactly the tuning word, modulo 2^PHASE_W
   p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(rst_n)) |->
         (phase_q == PHASE_W'($past(phase_q) + $past(ftw))));

endmodule

// File: rtl/tt_sine_rom.sv
module tt_sine_rom
   import tt_stim_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SAMP_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   output logic signed [SAMP_W-1:0] samp
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   if (ADDR_W < 4 || ADDR_W > 10) begin : g_bad_addr
      $error("tt_sine_rom: ADDR_W must lie in 4..10");
   end
   if (SAMP_W < 4 || SAMP_W > 16) begin : g_bad_samp
      $error("tt_sine_rom: SAMP_W must lie in 4..16");
   end

   logic signed [SAMP_W-1:0] tbl [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      localparam int VAL = sine_entry(k, ADDR_W, AMP);
      assign tbl[k] = SAMP_W'(VAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp <= '0;
      else        samp <= tbl[addr];
   end

   // R2: every sample stays inside the symmetric amplitude range
   p_sample_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(samp) <= AMP) && ($signed(samp) >= -AMP));

endmodule

// File: rtl/tt_tone_mix.sv
module tt_tone_mix #(
   parameter int SAMP_W    = 8,
   parameter bit REF_ALIGN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     single,
   input  logic signed [SAMP_W-1:0] tone_a,
   input  logic signed [SAMP_W-1:0] tone_b,
   input  logic signed [SAMP_W-1:0] tone_r,
   output logic signed [SAMP_W:0]   stim,
   output logic signed [SAMP_W-1:0] ref_samp
);

   localparam int SUM_W = SAMP_W + 1;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   logic signed [SUM_W-1:0] a_ext;
   logic signed [SUM_W-1:0] b_ext;

   assign a_ext = {tone_a[SAMP_W-1], tone_a};
   assign b_ext = single ? '0 : {tone_b[SAMP_W-1], tone_b};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stim <= '0;
      else        stim <= a_ext + b_ext;
   end

   if (REF_ALIGN) begin : g_ref_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ref_samp <= '0;
         else        ref_samp <= tone_r;
      end
      // R5: reference sample leaves one stage after lookup, level with the sum
      p_ref_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (ref_samp == $past(tone_r)));
   end else begin : g_ref_direct
      assign ref_samp = tone_r;
   end

   // R3: the summed word never exceeds twice the single-tone peak
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(stim) <= 2 * AMP) && ($signed(stim) >= -2 * AMP));

   // R7: in single-tone mode the output is tone 1 alone
   p_single_tone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(single) && $past(rst_n)) |-> ($signed(stim) == $signed($past(tone_a))));

endmodule

// File: rtl/tt_stim_gen.sv
module tt_stim_gen #(
   parameter int PHASE_W = 24,
   parameter int ADDR_W  = 8,
   parameter int SAMP_W  = 8
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     en_i,
   input  logic                     single_i,
   input  logic [PHASE_W-1:0]       fr1_i,
   input  logic [PHASE_W-1:0]       fr2_i,
   output logic signed [SAMP_W:0]   stim_o,
   output logic signed [SAMP_W-1:0] ref_o,
   output logic [PHASE_W-1:0]       ref_ftw_o
);

   localparam int NUM_CH = 3;
   localparam int CH_T1  = 0;
   localparam int CH_T2  = 1;
   localparam int CH_REF = 2;

   logic [PHASE_W-1:0]       ch_ftw  [NUM_CH];
   logic [ADDR_W-1:0]        ch_addr [NUM_CH];
   logic signed [SAMP_W-1:0] ch_samp [NUM_CH];

   // Upper third-order product: 2*f2 - f1, wrapping modulo the phase range
   assign ref_ftw_o      = (fr2_i << 1) - fr1_i;

   assign ch_ftw[CH_T1]  = fr1_i;
   assign ch_ftw[CH_T2]  = fr2_i;
   assign ch_ftw[CH_REF] = ref_ftw_o;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      tt_phase_acc #(
         .PHASE_W (PHASE_W),
         .ADDR_W  (ADDR_W)
      ) acc_i (
         .clk   (clk_i),
         .rst_n (rst_ni),
         .en    (en_i),
         .ftw   (ch_ftw[c]),
         .addr  (ch_addr[c])
      );

      tt_sine_rom #(
         .ADDR_W (ADDR_W),
         .SAMP_W (SAMP_W)
      ) rom_i (
         .clk   (clk_i),
         .rst_n (rst_ni),
         .addr  (ch_addr[c]),
         .samp  (ch_samp[c])
      );
   end

   tt_tone_mix #(
      .SAMP_W    (SAMP_W),
      .REF_ALIGN (1'b1)
   ) mix_i (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .single   (single_i),
      .tone_a   (ch_samp[CH_T1]),
      .tone_b   (ch_samp[CH_T2]),
      .tone_r   (ch_samp[CH_REF]),
      .stim     (stim_o),
      .ref_samp (ref_o)
   );

   // R9: outputs read zero while reset is held
   p_reset_quiet_r9: assert property (@(posedge clk_i)
      !rst_ni |-> (stim_o == '0 && ref_o == '0));

endmodule

// File: tb/tt_stim_gen_tb.sv
module tt_stim_gen_tb_top;

   localparam int N     = 24;
   localparam int AW    = 8;
   localparam longint MASK = (longint'(1) <<< N) - 1;
   localparam real PI   = 3.14159265358979323846;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               en = 1'b0;
   logic               single = 1'b0;
   logic [N-1:0]       fr1 = '0;
   logic [N-1:0]       fr2 = '0;
   logic signed [8:0]  stim;
   logic signed [7:0]  refs;
   logic [N-1:0]       ref_ftw;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural model state
   longint mp [3];
   int     ms [3];
   int     m_stim;
   int     m_ref;
   int     seen_max;
   int     seen_min;

   always #5 clk = ~clk;

   tt_stim_gen dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .en_i      (en),
      .single_i  (single),
      .fr1_i     (fr1),
      .fr2_i     (fr2),
      .stim_o    (stim),
      .ref_o     (refs),
      .ref_ftw_o (ref_ftw)
   );

   function automatic int tbl(input longint ph);
      int  k;
      real r;
      k = int'((ph >> (N - AW)) & 255);
      r = 127.0 * $sin(2.0 * PI * real'(k) / 256.0);
      return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // advance the model over one edge using the inputs now applied, then
   // compare the outputs at the following falling edge
   task automatic cyc(input string tag);
      longint f [3];
      f[0] = longint'(fr1);
      f[1] = longint'(fr2);
      f[2] = (2 * longint'(fr2) - longint'(fr1)) & MASK;
      m_stim = ms[0] + (single ? 0 : ms[1]);
      m_ref  = ms[2];
      for (int c = 0; c < 3; c++) ms[c] = tbl(mp[c]);
      for (int c = 0; c < 3; c++) mp[c] = en ? ((mp[c] + f[c]) & MASK) : 0;
      @(negedge clk);
      check({tag, " stim"}, longint'(stim), longint'(m_stim));
      check({tag, " ref R5"}, longint'(refs), longint'(m_ref));
      check("R4 ref word", longint'(ref_ftw), f[2]);
      if (int'(stim) > seen_max) seen_max = int'(stim);
      if (int'(stim) < seen_min) seen_min = int'(stim);
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 3; c++) begin
         mp[c] = 0;
         ms[c] = 0;
      end
      seen_max = 0;
      seen_min = 0;
      fr1 = 24'h123456;
      fr2 = 24'h0ABCDE;
      en  = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset holds outputs at zero even with enable and words set
      check("R9 stim in reset", longint'(stim), 0);
      check("R9 ref in reset", longint'(refs), 0);
      en = 1'b0;
      rst_n = 1'b1;

      // R2: one table entry per clock, walk the whole table
      fr1 = 24'(1 << (N - AW));
      fr2 = '0;
      single = 1'b0;
      cyc("R6 idle");
      en = 1'b1;
      for (int i = 0; i < 262; i++) cyc("R2 table walk R8");

      // R1: two unrelated tones, several words
      fr1 = 24'h0451A3;
      fr2 = 24'h04C2F1;
      for (int i = 0; i < 200; i++) cyc("R1 two-tone R3");
      fr1 = 24'h7FFFFF;
      fr2 = 24'h000123;
      for (int i = 0; i < 100; i++) cyc("R1 large word");

      // R4: fr1 above twice fr2 forces the derived word to wrap
      fr1 = 24'hF00000;
      fr2 = 24'h100000;
      #1;
      check("R4 wrap", longint'(ref_ftw), longint'(24'h300000));
      for (int i = 0; i < 60; i++) cyc("R4 wrap R5");

      // R6: enable drop parks phases; output zero two edges later
      en = 1'b0;
      cyc("R6 drop");
      cyc("R6 drop");
      cyc("R6 drop");
      check("R6 stim zero", longint'(stim), 0);
      check("R6 ref zero", longint'(refs), 0);

      // R3 with R7: coincident full-scale peaks while the mode toggles
      fr1 = 24'(1 << (N - 2));
      fr2 = 24'(1 << (N - 2));
      en = 1'b1;
      seen_max = 0;
      seen_min = 0;
      for (int i = 0; i < 40; i++) cyc("R3 peaks");
      check("R3 max 254", longint'(seen_max), 254);
      check("R3 min -254", longint'(seen_min), -254);
      for (int i = 0; i < 64; i++) begin
         single = (i % 3) == 1;
         cyc("R7 toggle R3");
      end
      single = 1'b1;
      fr2 = 24'h055555;
      for (int i = 0; i < 80; i++) cyc("R7 single");
      single = 1'b0;
      for (int i = 0; i < 20; i++) cyc("R7 back to sum");

      // R9: mid-run asynchronous reset
      #2 rst_n = 1'b0;
      #1;
      check("R9 async stim", longint'(stim), 0);
      check("R9 async ref", longint'(refs), 0);
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
         mp[c] = 0;
         ms[c] = 0;
      end
      rst_n = 1'b1;
      for (int i = 0; i < 30; i++) cyc("R9 restart R8");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule